// File: doc/BRIEF.md
# Serial Command Front End for a Dual-Channel Trimmer

This block is the slave-side serial port of a two-channel digital trimmer controller. A host shifts a 24-bit word into it while chip select is low. When chip select goes high again, the block splits the word into an operation code, a channel address and a data value. It then hands these to the register core as one single-cycle execute strobe. Every serial pin is brought into the system clock domain through a two-flop synchronizer and then edge-detected, so the block needs no clock of its own. Both idle-low (mode 0) and idle-high (mode 3) serial clocks are accepted.

The output line is open drain. It returns the word that was shifted in during the previous frame, so several devices can sit on one chain. After a read operation, the low 16 bits of that returning word are replaced with the value the core reports. After a step operation (increment, decrement, shift left, shift right), a bare chip-select pulse with no clocks in it repeats that step. This lets a push button drive the wiper. While the core reports that a nonvolatile operation is running, chip-select rises are ignored.

Top module: `trim_spi_front`

## Requirements
- R1: Input bits are taken on each rising serial-clock edge while chip select is low, most significant bit first. This holds whether the clock idles low (mode 0) or high (mode 3).
- R2: In the 24-bit word, bits [23:20] are the operation code, bits [19:16] the address and bits [15:0] the data, and each field reaches the matching execute output.
- R3: A frame of exactly 24 bits produces exactly one single-cycle `exe_valid` pulse after chip select rises. No pulse is issued while bits are still being shifted in.
- R4: While chip select is low, the output line presents the 24 bits shifted in during the previous frame, most significant bit first, one bit per rising edge.
- R5: After a read operation (code 2 or 3) executes, `rd_word` is sampled in the second clock after the `exe_valid` pulse. The next frame then returns the read frame's upper 8 bits followed by that sampled value.
- R6: After a step operation (codes 4 to 7) executes, each chip-select pulse with no clock edges in it issues `exe_valid` again with the same code and address and zero data. Any other executed operation cancels this. A bare pulse with no step stored issues nothing.
- R7: A frame whose bit count is neither 0 nor 24 is discarded. It issues no execute pulse and leaves the stored step unchanged.
- R8: If `core_busy` is high when chip select rises, nothing is issued and the stored step is unchanged.
- R9: `sdo_pull` is low whenever chip select is high. While chip select is low, `sdo_pull` goes high only to send a 0.
- R10: After reset, the returned word is all zeros, no step is stored and no execute pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host, asynchronous |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_mosi | input | 1 | Serial data in, asynchronous |
| sdo_pull | output | 1 | Open-drain pull-down enable for the serial data out line |
| core_busy | input | 1 | Core is running a nonvolatile operation |
| rd_word | input | 16 | Readback value from the core |
| exe_valid | output | 1 | Single-cycle execute strobe |
| exe_cmd | output | 4 | Operation code |
| exe_addr | output | 4 | Channel or register address |
| exe_data | output | 16 | Data field |

## Verification
The assertions check on every cycle that:
- each execute strobe lasts a single cycle and directly follows a synchronized chip-select rise;
- no strobe follows a rise seen while busy;
- the bit count only grows within a frame;
- a strobe comes only from a full 24-bit frame or from an empty one.

Only the bench scenarios can show the following: that field values arrive intact in both clock modes, and that the returned word matches the previous frame or carries the readback value in its low half. They also show that steps are repeated and then cancelled, and that malformed or busy frames leave the stored step in place.

// File: rtl/trim_spi_pkg.sv
package trim_spi_pkg;
    localparam int FRAME_W = 24;
    localparam int CMD_W   = 4;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = FRAME_W - CMD_W - ADDR_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    typedef enum logic [CMD_W-1:0] {
        OP_NOP     = 4'd0,
        OP_WRITE   = 4'd1,
        OP_RD_LIVE = 4'd2,
        OP_RD_NV   = 4'd3,
        OP_STEP_UP = 4'd4,
        OP_STEP_DN = 4'd5,
        OP_SHL     = 4'd6,
        OP_SHR     = 4'd7
    } op_e;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic logic is_step(input logic [CMD_W-1:0] c);
        return (c == OP_STEP_UP) || (c == OP_STEP_DN) || (c == OP_SHL) || (c == OP_SHR);
    endfunction

    function automatic logic is_read(input logic [CMD_W-1:0] c);
        return (c == OP_RD_LIVE) || (c == OP_RD_NV);
    endfunction
endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/trim_shifter.sv
module trim_shifter
    import trim_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              cs_fall,
    input  logic              sck_rise,
    input  logic              mosi,
    input  logic              rb_load,
    input  logic [DATA_W-1:0] rb_data,
    output frame_t            word,
    output logic [CNT_W-1:0]  cnt,
    output logic              msb
);
    logic [FRAME_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (cs_fall) begin
            cnt <= '0;
        end else if (sck_rise && cs_act) begin
            shreg <= {shreg[FRAME_W-2:0], mosi};
            if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        end else if (rb_load) begin
            shreg[DATA_W-1:0] <= rb_data;
        end
    end

    assign word = frame_t'(shreg);
    assign msb  = shreg[FRAME_W-1];

    // R1: bit count never shrinks inside a frame
    p_cnt_grow_r1: assert property (@(posedge clk) disable iff (rst)
        (cs_act && !cs_fall) |=> (cnt >= $past(cnt)));
endmodule

// File: rtl/trim_exec.sv
module trim_exec
    import trim_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_rise,
    input  logic              busy,
    input  logic [CNT_W-1:0]  cnt,
    input  frame_t            word,
    output logic              exe_valid,
    output logic [CMD_W-1:0]  exe_cmd,
    output logic [ADDR_W-1:0] exe_addr,
    output logic [DATA_W-1:0] exe_data,
    output logic              rb_load
);
    logic              step_vld;
    logic [CMD_W-1:0]  step_cmd;
    logic [ADDR_W-1:0] step_addr;
    logic              rb_arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            exe_valid <= 1'b0;
            exe_cmd   <= '0;
            exe_addr  <= '0;
            exe_data  <= '0;
            step_vld  <= 1'b0;
            step_cmd  <= '0;
            step_addr <= '0;
            rb_arm    <= 1'b0;
            rb_load   <= 1'b0;
        end else begin
            exe_valid <= 1'b0;
            rb_arm    <= exe_valid && is_read(exe_cmd);
            rb_load   <= rb_arm;
            if (cs_rise && !busy) begin
                if (cnt == CNT_FULL) begin
                    exe_valid <= 1'b1;
                    exe_cmd   <= word.cmd;
                    exe_addr  <= word.addr;
                    exe_data  <= word.data;
                    step_vld  <= is_step(word.cmd);
                    step_cmd  <= word.cmd;
                    step_addr <= word.addr;
                end else if (cnt == '0 && step_vld) begin
                    exe_valid <= 1'b1;
                    exe_cmd   <= step_cmd;
                    exe_addr  <= step_addr;
                    exe_data  <= '0;
                end
            end
        end
    end

    // R3: strobe lasts one cycle
    p_one_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        exe_valid |=> !exe_valid);
    // R3: strobe only follows a chip-select rise
    p_after_rise_r3: assert property (@(posedge clk) disable iff (rst)
        exe_valid |-> $past(cs_rise));
    // R8: nothing issued from a busy rise
    p_busy_lock_r8: assert property (@(posedge clk) disable iff (rst)
        exe_valid |-> !$past(busy));
endmodule

// File: rtl/trim_spi_front.sv
module trim_spi_front
    import trim_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              sdo_pull,
    input  logic              core_busy,
    input  logic [DATA_W-1:0] rd_word,
    output logic              exe_valid,
    output logic [CMD_W-1:0]  exe_cmd,
    output logic [ADDR_W-1:0] exe_addr,
    output logic [DATA_W-1:0] exe_data
);
    logic [2:0]       pins_q;
    logic             sck_q, cs_n_q, mosi_q;
    logic             sck_d, cs_n_d;
    logic             sck_rise, cs_rise, cs_fall, cs_act;
    frame_t           word;
    logic [CNT_W-1:0] cnt;
    logic             msb;
    logic             rb_load;

    trim_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_sck, spi_cs_n, spi_mosi}),
        .q   (pins_q)
    );
    assign {sck_q, cs_n_q, mosi_q} = pins_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d  <= 1'b0;
            cs_n_d <= 1'b1;
        end else begin
            sck_d  <= sck_q;
            cs_n_d <= cs_n_q;
        end
    end

    assign sck_rise = sck_q & ~sck_d;
    assign cs_rise  = cs_n_q & ~cs_n_d;
    assign cs_fall  = ~cs_n_q & cs_n_d;
    assign cs_act   = ~cs_n_q;

    trim_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .cs_act   (cs_act),
        .cs_fall  (cs_fall),
        .sck_rise (sck_rise),
        .mosi     (mosi_q),
        .rb_load  (rb_load),
        .rb_data  (rd_word),
        .word     (word),
        .cnt      (cnt),
        .msb      (msb)
    );

    trim_exec u_exec (
        .clk       (clk),
        .rst       (rst),
        .cs_rise   (cs_rise),
        .busy      (core_busy),
        .cnt       (cnt),
        .word      (word),
        .exe_valid (exe_valid),
        .exe_cmd   (exe_cmd),
        .exe_addr  (exe_addr),
        .exe_data  (exe_data),
        .rb_load   (rb_load)
    );

    assign sdo_pull = cs_act & ~msb;

    // R7: a strobe only comes from a full or an empty frame
    p_frame_len_r7: assert property (@(posedge clk) disable iff (rst)
        exe_valid |-> ($past(cnt) == CNT_FULL || $past(cnt) == '0));
endmodule

// File: tb/trim_spi_front_bench.sv
module trim_spi_front_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        busy = 1'b0;
    logic [15:0] rd_word = 16'hBEEF;
    logic        sdo_pull, exe_valid;
    logic [3:0]  exe_cmd, exe_addr;
    logic [15:0] exe_data;

    int total = 0, bad = 0, n_exe = 0;
    logic [3:0]  l_cmd, l_addr;
    logic [15:0] l_data;
    localparam int HALF = 5;

    always #10 clk = ~clk;

    trim_spi_front u_trim_spi_front (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .sdo_pull(sdo_pull), .core_busy(busy), .rd_word(rd_word),
        .exe_valid(exe_valid), .exe_cmd(exe_cmd), .exe_addr(exe_addr), .exe_data(exe_data)
    );

    always @(posedge clk) if (exe_valid) begin
        n_exe++;
        l_cmd = exe_cmd; l_addr = exe_addr; l_data = exe_data;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input bit mode3, input logic [23:0] tx, input int nbits,
                        output logic [23:0] rx);
        rx = '0;
        sck = mode3;
        waitc(2 * HALF);
        cs_n = 1'b0;
        waitc(HALF);
        for (int i = 0; i < nbits; i++) begin
            if (mode3) sck = 1'b0;
            mosi = tx[23 - i];
            waitc(HALF);
            rx = {rx[22:0], ~sdo_pull};
            sck = 1'b1;
            waitc(HALF);
            if (!mode3) sck = 1'b0;
        end
        waitc(HALF);
        cs_n = 1'b1;
        waitc(12);
    endtask

    task automatic strobe;
        cs_n = 1'b0;
        waitc(8);
        cs_n = 1'b1;
        waitc(12);
    endtask

    task automatic t_reset;
        chk("R10 no strobe", n_exe, 0);
        chk("R9 released at reset", sdo_pull, 0);
    endtask

    task automatic t_write_mode0;
        logic [23:0] rx; int n0 = n_exe;
        xfer(1'b0, 24'h100155, 24, rx);
        chk("R3 one strobe", n_exe - n0, 1);
        chk("R2 cmd", l_cmd, 4'h1);
        chk("R2 addr", l_addr, 4'h0);
        chk("R2 data", l_data, 16'h0155);
        chk("R10 zero word after reset", rx, 24'h0);
    endtask

    task automatic t_daisy_mode3;
        logic [23:0] rx; int n0 = n_exe;
        xfer(1'b1, 24'h1103AA, 24, rx);
        chk("R4 previous word out", rx, 24'h100155);
        chk("R1 mode3 strobe", n_exe - n0, 1);
        chk("R1 mode3 fields", {l_cmd, l_addr, l_data}, 24'h1103AA);
    endtask

    task automatic t_readback;
        logic [23:0] rx;
        xfer(1'b0, 24'h210000, 24, rx);
        chk("R4 chain word", rx, 24'h1103AA);
        chk("R5 read cmd", l_cmd, 4'h2);
        xfer(1'b0, 24'h000000, 24, rx);
        chk("R5 readback word", rx, 24'h21BEEF);
    endtask

    task automatic t_step_lock;
        logic [23:0] rx; int n0;
        xfer(1'b0, 24'h40FFFF, 24, rx);
        n0 = n_exe;
        strobe();
        chk("R6 replay count", n_exe - n0, 1);
        chk("R6 replay fields", {l_cmd, l_addr, l_data}, 24'h400000);
        strobe();
        chk("R6 second replay", n_exe - n0, 2);
        n0 = n_exe;
        xfer(1'b0, 24'h1F0000, 10, rx);
        chk("R7 short frame dropped", n_exe - n0, 0);
        strobe();
        chk("R7 step kept", {l_cmd, 4'(n_exe - n0)}, {4'h4, 4'd1});
        busy = 1'b1;
        n0 = n_exe;
        xfer(1'b0, 24'h100022, 24, rx);
        strobe();
        chk("R8 busy blocks", n_exe - n0, 0);
        busy = 1'b0;
        strobe();
        chk("R8 step kept", {l_cmd, 4'(n_exe - n0)}, {4'h4, 4'd1});
        xfer(1'b0, 24'h100001, 24, rx);
        n0 = n_exe;
        strobe();
        chk("R6 cancelled", n_exe - n0, 0);
    endtask

    task automatic t_release;
        chk("R9 released when cs high", sdo_pull, 0);
        cs_n = 1'b0;
        waitc(6);
        chk("R9 pulls for zero msb", sdo_pull, 1);
        cs_n = 1'b1;
        waitc(6);
        chk("R9 released again", sdo_pull, 0);
    endtask

    initial begin
        waitc(6);
        rst = 1'b0;
        waitc(4);
        t_reset();
        t_write_mode0();
        t_daisy_mode3();
        t_readback();
        t_step_lock();
        t_release();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule